// File: doc/BRIEF.md
# Radix-4 Carry-Save Montgomery Stage

This block is one stage of a word-serial Montgomery multiplier pipeline. It performs one radix-4 iteration of the modular product. Each clock it takes one w-bit word of the multiplicand Y, of the odd modulus M, and of the partial result S. S is held in carry-save form as a sum vector and a carry vector. It also takes a 3-bit window of the multiplier X and a flag that marks the least significant word. Words arrive least significant first.

The stage adds a signed multiple Z·Y of the multiplicand, with Z in {-2..2}. It then adds a multiple q·M of the modulus, with q in {-1, 0, 1, 2}. q is chosen so that the two lowest bits of the total vanish. The stage divides the result by four by shifting the words right by two bits. Words of Y, M and the new result leave two cycles after they arrive, so the next stage of the same kind can consume them directly.

When the two discarded low bits of the sum and carry vectors add up to four, that weight is not lost. It leaves the stage as a single hidden bit, and the next stage adds it at bit 0.

Top module: `mont_r4_stage`

## Requirements
- R1: The X window is decoded only on the word flagged first and held for the rest of the operation. The window on later words has no effect. Window to digit Z: 000→0, 001→+1, 010→+1, 011→+2, 100→-2, 101→-1, 110→-1, 111→0.
- R2: A negative multiple of Y is formed as the bitwise complement plus one. The one is added only on the first word, and the carry crosses every later word boundary.
- R3: For Z = ±2, the doubled multiple shifts in the top bit of the previous Y word at bit 0. On the first word it shifts in 0. The doubled modulus 2M is formed the same way.
- R4: The quotient is picked from NR = (low two bits of S + Z·Y + hidden input) mod 4. When M bit 1 is 0, NR 0,1,2,3 gives q = 0,-1,2,1. When M bit 1 is 1, it gives q = 0,1,2,-1.
- R5: -M is formed without a carry-in. Bits w-1..1 of the first word are complemented and bit 0 is forced to 1. Every bit of the later words is complemented.
- R6: Input word k spans operand bits [w·k+w-1 : w·k]. Output word k is valid in the second cycle after input word k. Over an operation of e words, (SS_out + SC_out + hidden_out) mod 2^(w·e-2) equals (SS + SC + hidden_in + Z·Y + q·M)/4 mod 2^(w·e-2).
- R7: The hidden input present with the first word is added with weight 1 at bit 0 of the operation.
- R8: The Y and M words appear at the outputs unchanged, two cycles after they enter.
- R9: While reset is asserted, every output is zero.
- R10: The first-word flag separates operations that are fed back to back. No carry, shifted bit or digit from one operation affects the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| first_i | input | 1 | Marks the least significant word of an operation |
| xdig_i | input | 3 | Multiplier window for this iteration (two digit bits and the bit below them) |
| hid_i | input | 1 | Hidden bit from the previous stage, taken with the first word |
| y_i | input | WORD | Multiplicand word |
| m_i | input | WORD | Modulus word (the modulus is odd) |
| ss_i | input | WORD | Partial result, sum-vector word |
| sc_i | input | WORD | Partial result, carry-vector word |
| y_o | output | WORD | Multiplicand word forwarded |
| m_o | output | WORD | Modulus word forwarded |
| ss_o | output | WORD | New partial result shifted right by two, sum-vector word |
| sc_o | output | WORD | New partial result shifted right by two, carry-vector word |
| hid_o | output | 1 | Hidden bit of the current operation |

## Verification
Suppose a carry register, a shifted-in bit, the held digit or the held quotient is wrong. The assimilated output value then differs from the integer model of one radix-4 step. The error shows in the output word that covers the faulty bit position, and that word appears two cycles after the matching input word. A wrong hidden bit or a wrong quotient corrupts the low end of the value at once, in the first output word. A leak between operations shows only when operations are fed back to back, in the first words of the second operation.

// File: rtl/mont_r4_stage.sv
module mont_r4_stage #(
  parameter int WORD = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            first_i,
  input  logic [2:0]      xdig_i,
  input  logic            hid_i,
  input  logic [WORD-1:0] y_i,
  input  logic [WORD-1:0] m_i,
  input  logic [WORD-1:0] ss_i,
  input  logic [WORD-1:0] sc_i,
  output logic [WORD-1:0] y_o,
  output logic [WORD-1:0] m_o,
  output logic [WORD-1:0] ss_o,
  output logic [WORD-1:0] sc_o,
  output logic            hid_o
);
  localparam int TOP = WORD - 1;

  // digit decode: {zero, double, negative}
  logic       dz, dd, dn;
  logic [2:0] zdn_r, zdn;
  assign dz  = (xdig_i == 3'b000) | (xdig_i == 3'b111);
  assign dd  = (xdig_i == 3'b011) | (xdig_i == 3'b100);
  assign dn  = xdig_i[2] & ~dz;
  assign zdn = first_i ? {dz, dd, dn} : zdn_r;

  // section 1: S + Z*Y
  logic            ymsb_r, spill1_r;
  logic [WORD-1:0] y2, ysel, ymul, s1, c1, maj1;
  assign y2   = {y_i[TOP-1:0], first_i ? 1'b0 : ymsb_r};
  assign ysel = zdn[2] ? '0 : (zdn[1] ? y2 : y_i);
  assign ymul = zdn[0] ? ~ysel : ysel;
  assign s1   = ss_i ^ sc_i ^ ymul;
  assign maj1 = (ss_i & sc_i) | (ss_i & ymul) | (sc_i & ymul);
  assign c1   = {maj1[TOP-1:0], first_i ? zdn[0] : spill1_r};

  logic [WORD-1:0] s1_r, c1_r, y_r, m_r;
  logic            first_r, hid_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zdn_r    <= '0;
      ymsb_r   <= 1'b0;
      spill1_r <= 1'b0;
      s1_r     <= '0;
      c1_r     <= '0;
      y_r      <= '0;
      m_r      <= '0;
      first_r  <= 1'b0;
      hid_r    <= 1'b0;
    end else begin
      s1_r     <= s1;
      c1_r     <= c1;
      spill1_r <= maj1[TOP];
      ymsb_r   <= y_i[TOP];
      y_r      <= y_i;
      m_r      <= m_i;
      first_r  <= first_i;
      if (first_i) begin
        zdn_r <= {dz, dd, dn};
        hid_r <= hid_i;
      end
    end
  end

  // quotient: 0 none, 1 +M, 2 +2M, 3 -M
  logic [1:0] nr, qdec, q_r, q;
  assign nr   = s1_r[1:0] + c1_r[1:0] + {1'b0, hid_r};
  assign qdec = m_r[1] ? nr : {nr[1] ^ nr[0], nr[0]};
  assign q    = first_r ? qdec : q_r;

  // section 2: + q*M
  logic            mmsb_r, spill2_r;
  logic [WORD-1:0] m2, mneg, mmul, s2, c2, maj2;
  assign m2   = {m_r[TOP-1:0], first_r ? 1'b0 : mmsb_r};
  assign mneg = {~m_r[TOP:1], first_r ? 1'b1 : ~m_r[0]};

  always_comb begin
    case (q)
      2'd1:    mmul = m_r;
      2'd2:    mmul = m2;
      2'd3:    mmul = mneg;
      default: mmul = '0;
    endcase
  end

  assign s2   = s1_r ^ c1_r ^ mmul;
  assign maj2 = (s1_r & c1_r) | (s1_r & mmul) | (c1_r & mmul);
  assign c2   = {maj2[TOP-1:0], first_r ? hid_r : spill2_r};

  logic [WORD-3:0] up_ss_r, up_sc_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r      <= '0;
      mmsb_r   <= 1'b0;
      spill2_r <= 1'b0;
      up_ss_r  <= '0;
      up_sc_r  <= '0;
      y_o      <= '0;
      m_o      <= '0;
      hid_o    <= 1'b0;
    end else begin
      mmsb_r   <= m_r[TOP];
      spill2_r <= maj2[TOP];
      up_ss_r  <= s2[TOP:2];
      up_sc_r  <= c2[TOP:2];
      y_o      <= y_r;
      m_o      <= m_r;
      if (first_r) begin
        q_r   <= qdec;
        hid_o <= |{s2[1:0], c2[1:0]};
      end
    end
  end

  assign ss_o = {s2[1:0], up_ss_r};
  assign sc_o = {c2[1:0], up_sc_r};
endmodule

module mont_r4_stage_chk #(
  parameter int WORD = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            first_i,
  input logic [WORD-1:0] y_i,
  input logic [WORD-1:0] m_i,
  input logic [WORD-1:0] y_o,
  input logic [WORD-1:0] m_o,
  input logic [WORD-1:0] ss_o,
  input logic [WORD-1:0] sc_o,
  input logic            hid_o
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_Y_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (y_o == $past(y_i, 2)));  // R8
  AST_M_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (m_o == $past(m_i, 2)));  // R8
  AST_HIDDEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc == 2'd3) && !$past(first_i, 2)) |-> $stable(hid_o));  // R6

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (y_o == '0 && m_o == '0 && ss_o == '0 && sc_o == '0 && !hid_o);  // R9
    end
  end
endmodule

bind mont_r4_stage mont_r4_stage_chk #(.WORD(WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .first_i(first_i), .y_i(y_i), .m_i(m_i),
  .y_o(y_o), .m_o(m_o), .ss_o(ss_o), .sc_o(sc_o), .hid_o(hid_o)
);

// File: tb/test_mont_r4_stage.sv
module test_mont_r4_stage;
  localparam int WORD = 8;
  localparam int NW   = 4;
  localparam int WT   = WORD * NW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            first_i = 1'b0;
  logic [2:0]      xdig_i = '0;
  logic            hid_i = 1'b0;
  logic [WORD-1:0] y_i = '0, m_i = '0, ss_i = '0, sc_i = '0;
  logic [WORD-1:0] y_o, m_o, ss_o, sc_o;
  logic            hid_o;

  int tests = 0;
  int fails = 0;

  logic [WT-1:0] got_ss [2];
  logic [WT-1:0] got_sc [2];
  logic [WT-1:0] got_y  [2];
  logic [WT-1:0] got_m  [2];
  logic          got_h  [2];

  always #5 clk = ~clk;

  mont_r4_stage #(.WORD(WORD)) i_mont_r4_stage (
    .clk(clk), .rst_n(rst_n), .first_i(first_i), .xdig_i(xdig_i), .hid_i(hid_i),
    .y_i(y_i), .m_i(m_i), .ss_i(ss_i), .sc_i(sc_i),
    .y_o(y_o), .m_o(m_o), .ss_o(ss_o), .sc_o(sc_o), .hid_o(hid_o)
  );

  // {xdig, hid, y, m, ss, sc}: R1 R2 R3 R4 R5 R6 R7 patterns
  localparam logic [131:0] VEC [10] = '{
    {3'b000, 1'b0, 32'h12345678, 32'h0F0F0F0F, 32'h01020304, 32'h00000007},
    {3'b001, 1'b1, 32'h1ABCDEF1, 32'h12345671, 32'h0000FFFF, 32'h00FF00FF},
    {3'b010, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFD, 32'h11111111, 32'h22222222},
    {3'b011, 1'b1, 32'h80808080, 32'h00000003, 32'hFFFFFFFF, 32'h00000001},
    {3'b100, 1'b0, 32'h0000FF80, 32'h0BADF00D, 32'h0F0F0F0F, 32'hF0F0F0F0},
    {3'b101, 1'b1, 32'h13579BDF, 32'h2468ACE1, 32'h00000000, 32'h00000000},
    {3'b110, 1'b0, 32'hDEADBEEF, 32'h7654321B, 32'h00000002, 32'h00000001},
    {3'b111, 1'b1, 32'h55555555, 32'h33333333, 32'h00000003, 32'h00000000},
    {3'b011, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80000000, 32'h80000000},
    {3'b100, 1'b1, 32'h00000001, 32'h00000001, 32'h00000003, 32'h00000003}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [WT-3:0] ref_step(input logic [131:0] v);
    int z;
    longint a;
    logic [WT-3:0] res;
    case (v[131:129])
      3'b001, 3'b010: z = 1;
      3'b011:         z = 2;
      3'b100:         z = -2;
      3'b101, 3'b110: z = -1;
      default:        z = 0;
    endcase
    a = longint'(v[63:32]) + longint'(v[31:0]) + longint'(v[128]) + longint'(z) * longint'(v[127:96]);
    res = '0;
    for (int q = -1; q <= 2; q++) begin
      longint t;
      logic [63:0] u;
      t = a + longint'(q) * longint'(v[95:64]);
      u = t;
      if (u[1:0] == 2'b00) res = u[WT-1:2];
    end
    return res;
  endfunction

  task automatic stream(input logic [131:0] va, input logic [131:0] vb, input bit two);
    int n;
    n = two ? 2 * NW + 2 : NW + 2;
    for (int c = 0; c < n; c++) begin
      int k, o, idx;
      logic [131:0] v;
      bit act;
      @(negedge clk);
      if (c >= 2) begin
        k = (c - 2) % NW;
        o = (c - 2) / NW;
        got_ss[o][k*WORD +: WORD] = ss_o;
        got_sc[o][k*WORD +: WORD] = sc_o;
        got_y[o][k*WORD +: WORD]  = y_o;
        got_m[o][k*WORD +: WORD]  = m_o;
        if (k == 0) got_h[o] = hid_o;
      end
      act = 1'b0; idx = 0; v = '0;
      if (c < NW) begin act = 1'b1; idx = c; v = va; end
      else if (two && c < 2 * NW) begin act = 1'b1; idx = c - NW; v = vb; end
      first_i = act && (idx == 0);
      xdig_i  = act ? ((idx == 0) ? v[131:129] : ~v[131:129]) : 3'b000;
      hid_i   = act ? ((idx == 0) ? v[128] : ~v[128]) : 1'b0;
      y_i     = act ? v[96 + idx*WORD +: WORD] : '0;
      m_i     = act ? v[64 + idx*WORD +: WORD] : '0;
      ss_i    = act ? v[32 + idx*WORD +: WORD] : '0;
      sc_i    = act ? v[idx*WORD +: WORD] : '0;
    end
  endtask

  function automatic logic [WT-3:0] got_val(input int o);
    logic [WT-1:0] tot;
    tot = got_ss[o] + got_sc[o] + {{(WT-1){1'b0}}, got_h[o]};
    return tot[WT-3:0];
  endfunction

  task automatic op_check(input string tag, input logic [131:0] v);
    stream(v, '0, 1'b0);
    chk(tag, 64'(got_val(0)), 64'(ref_step(v)));
  endtask

  initial begin
    #2_000_000;
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 outputs in reset", {y_o, m_o, ss_o, sc_o, 31'b0, hid_o}, 64'b0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      stream(VEC[i], '0, 1'b0);
      chk($sformatf("R4 R6 step result vec %0d", i), 64'(got_val(0)), 64'(ref_step(VEC[i])));
      chk($sformatf("R8 Y forward vec %0d", i), 64'(got_y[0]), 64'(VEC[i][127:96]));
      chk($sformatf("R8 M forward vec %0d", i), 64'(got_m[0]), 64'(VEC[i][95:64]));
    end

    op_check("R1 digit +2 held, later windows ignored", {3'b011, 1'b0, 32'h00C3A5F0, 32'h00010001, 32'h00000000, 32'h00000000});
    op_check("R1 digit zero gives zero result",        {3'b111, 1'b0, 32'hFFFFFFFF, 32'h00000101, 32'h00000000, 32'h00000000});
    op_check("R2 minus Y carry across zero words",     {3'b101, 1'b0, 32'h12000000, 32'h00000101, 32'h00000000, 32'h00000000});
    op_check("R3 doubled Y across word boundaries",    {3'b100, 1'b0, 32'h80808080, 32'h00000005, 32'h00000000, 32'h00000000});
    op_check("R3 doubled M across word boundaries",    {3'b000, 1'b0, 32'h00000000, 32'h80808081, 32'h00000002, 32'h00000000});
    op_check("R5 minus M with M bit1 clear",           {3'b000, 1'b0, 32'h00000000, 32'h00010001, 32'h00000001, 32'h00000000});
    op_check("R5 minus M with M bit1 set",             {3'b000, 1'b0, 32'h00000000, 32'h7F7F7F7F, 32'h00000003, 32'h00000000});
    op_check("R7 hidden input weight one",             {3'b000, 1'b1, 32'h00000000, 32'h00000005, 32'h00000003, 32'h00000000});

    stream(VEC[8], VEC[3], 1'b1);
    chk("R10 back to back first op",  64'(got_val(0)), 64'(ref_step(VEC[8])));
    chk("R10 back to back second op", 64'(got_val(1)), 64'(ref_step(VEC[3])));
    stream(VEC[5], VEC[2], 1'b1);
    chk("R10 back to back third op",  64'(got_val(0)), 64'(ref_step(VEC[5])));
    chk("R10 back to back fourth op", 64'(got_val(1)), 64'(ref_step(VEC[2])));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule